// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides, each cycle, whether a three-stage in-order core enters debug halt and which style of entry it uses. An IRQ-like entry fits in between the stage-2 and stage-3 instructions, so the stage-3 instruction retires and the debug PC is the stage-2 PC. An exception-like entry replaces the stage-3 instruction, and the debug PC is the stage-3 PC. A plain external halt request uses the IRQ-like style, because the stage-3 instruction may already have touched the system, for example through an IO load or store. An ebreak that has been redirected to debug uses the exception-like style.

If a halt request arrives in the same cycle that the stage-3 instruction raises an exception, the entry is exception-like. The debug PC then names the faulting instruction, not the instruction after it, which is never reached. An exception-like halt also masks the regular trap strobe, so the machine trap state is left alone. The debug PC and a cause code are captured on the clock edge that closes the strobe cycle.

A small state machine tracks the handshake with the debug-mode flag, which the surrounding logic owns. The states are RUN, ENTER and HALTED. RUN goes to ENTER when a halt strobe fires, and goes straight to HALTED if the flag is already high. ENTER goes to HALTED once the flag rises. HALTED goes back to RUN when the flag falls. Halt strobes can fire only in RUN, and only while the flag is low.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: With halt_req high, no exception (exc_code 4'd15 means none) and entry allowed, halt_irq_o is 1 and halt_exc_o and trap_o are 0. After the next clock edge, dpc_o equals pc_s2_i and cause_o equals 3.
- R2: With exc_code 4'd3 (ebreak) and ebreak_dbg_en_i set, halt_exc_o is 1 and trap_o is 0 whatever halt_req is. After the next edge, dpc_o equals pc_s3_i and cause_o equals 1.
- R3: With exc_code 4'd3 and ebreak_dbg_en_i clear, trap_o is 1, unless R4 applies.
- R4: With halt_req high and a regular exception present (any code other than 15, and not a redirected ebreak), halt_exc_o is 1 and trap_o is 0. After the next edge, dpc_o equals pc_s3_i and cause_o equals 3.
- R5: A regular exception without a halt request gives trap_o = 1 and no halt strobe. Code 15 gives trap_o = 0.
- R6: No halt strobe fires while in_debug_i is high. dpc_o and cause_o hold their values in every cycle without a halt strobe.
- R7: After a halt strobe, no new halt strobe fires until in_debug_i has risen and then fallen again (states ENTER and HALTED).
- R8: halt_exc_o and halt_irq_o are never high together.
- R9: With DEBUG_EN = 0, no halt strobe ever fires, trap_o = (exc_code != 15), and dpc_o and cause_o stay 0.
- R10: After reset, the FSM is in RUN, dpc_o = 0, cause_o = 0, and the strobes follow only the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_code_i | input | 4 | Exception code of the stage-3 instruction (15 = none, 3 = ebreak, 5 = load fault) |
| pc_s3_i | input | XLEN | PC of the stage-3 instruction |
| pc_s2_i | input | XLEN | PC of the stage-2 instruction |
| halt_req_i | input | 1 | External halt request |
| ebreak_dbg_en_i | input | 1 | Redirect ebreak to debug halt |
| in_debug_i | input | 1 | Core is in debug mode |
| halt_exc_o | output | 1 | Exception-like halt entry strobe |
| halt_irq_o | output | 1 | IRQ-like halt entry strobe |
| trap_o | output | 1 | Regular machine trap strobe |
| dpc_o | output | XLEN | Captured debug PC |
| cause_o | output | 3 | Captured halt cause (1 ebreak, 3 halt request) |

## Verification
The hardest case to reach is a halt request that meets an exception in the very cycle the machine is in RUN with the debug flag low. The next hardest is a halt request held through the ENTER state, before the flag has risen. The bench sweeps every exception code against both halt-request values and both enable values, always from RUN. After each entry it walks the handshake: it holds the halt request high through ENTER and through HALTED, and checks that no strobe fires and that the captured PC stays put. A second instance built with debug support off sees the same stimulus.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
    localparam int EXC_W   = 4;
    localparam int CAUSE_W = 3;

    localparam logic [EXC_W-1:0] EXC_EBREAK = 4'd3;
    localparam logic [EXC_W-1:0] EXC_LDFLT  = 4'd5;
    localparam logic [EXC_W-1:0] EXC_NONE   = 4'd15;

    localparam logic [CAUSE_W-1:0] CAUSE_EBREAK = 3'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_HALTRQ = 3'd3;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ENTER  = 2'd1,
        ST_HALTED = 2'd2
    } dbg_state_t;
endpackage

// File: rtl/dbg_halt_classify.sv
module dbg_halt_classify
    import dbg_halt_pkg::*;
#(
    parameter bit DEBUG_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXC_W-1:0] exc_code_i,
    input  logic             halt_req_i,
    input  logic             ebreak_dbg_en_i,
    input  logic             allow_i,
    output logic             halt_exc_o,
    output logic             halt_irq_o,
    output logic             trap_o,
    output logic             brk_dbg_o
);
    logic brk_dbg;
    logic exc_any;

    always_comb begin
        brk_dbg    = DEBUG_EN && ebreak_dbg_en_i && (exc_code_i == EXC_EBREAK);
        exc_any    = (exc_code_i != EXC_NONE) && !brk_dbg;
        // exception-like causes outrank the IRQ-like halt request
        halt_exc_o = DEBUG_EN && allow_i && (brk_dbg || (halt_req_i && exc_any));
        halt_irq_o = DEBUG_EN && allow_i && halt_req_i && !halt_exc_o;
        trap_o     = exc_any && !halt_exc_o;
        brk_dbg_o  = brk_dbg;
    end

    // R8
    one_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_exc_o, halt_irq_o}));

    // R4
    req_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_i && allow_i && DEBUG_EN && exc_code_i == EXC_LDFLT) |-> (halt_exc_o && !trap_o));

    // R5
    none_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_code_i == EXC_NONE) |-> !trap_o);
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
    import dbg_halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic in_debug_i,
    output logic allow_o
);
    dbg_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (in_debug_i)   state_d = ST_HALTED;  // flag already up
                else if (enter_i) state_d = ST_ENTER;   // halt strobe fired
            end
            ST_ENTER:  if (in_debug_i)  state_d = ST_HALTED; // flag rose
            ST_HALTED: if (!in_debug_i) state_d = ST_RUN;    // resumed
            default:                    state_d = ST_RUN;
        endcase
    end

    always_comb begin
        allow_o = (state_q == ST_RUN) && !in_debug_i;
    end

    // R7
    no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> !enter_i);

    // R6
    no_halt_in_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_debug_i |-> !enter_i);

    // R7
    enter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && enter_i) |=> (state_q == ST_ENTER));
endmodule

// File: rtl/dbg_halt_capture.sv
module dbg_halt_capture
    import dbg_halt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_exc_i,
    input  logic               halt_irq_i,
    input  logic               brk_dbg_i,
    input  logic [XLEN-1:0]    pc_s3_i,
    input  logic [XLEN-1:0]    pc_s2_i,
    output logic [XLEN-1:0]    dpc_o,
    output logic [CAUSE_W-1:0] cause_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dpc_o   <= '0;
            cause_o <= '0;
        end else if (halt_exc_i) begin
            dpc_o   <= pc_s3_i;
            cause_o <= brk_dbg_i ? CAUSE_EBREAK : CAUSE_HALTRQ;
        end else if (halt_irq_i) begin
            dpc_o   <= pc_s2_i;
            cause_o <= CAUSE_HALTRQ;
        end
    end

    // R1
    irq_dpc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_irq_i |=> (dpc_o == $past(pc_s2_i) && cause_o == CAUSE_HALTRQ));

    // R2
    exc_dpc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_exc_i |=> (dpc_o == $past(pc_s3_i)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_exc_i || halt_irq_i) |=> ($stable(dpc_o) && $stable(cause_o)));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit DEBUG_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         exc_code_i,
    input  logic [XLEN-1:0]    pc_s3_i,
    input  logic [XLEN-1:0]    pc_s2_i,
    input  logic               halt_req_i,
    input  logic               ebreak_dbg_en_i,
    input  logic               in_debug_i,
    output logic               halt_exc_o,
    output logic               halt_irq_o,
    output logic               trap_o,
    output logic [XLEN-1:0]    dpc_o,
    output logic [2:0]         cause_o
);
    logic allow;
    logic brk_dbg;

    dbg_halt_classify #(.DEBUG_EN(DEBUG_EN)) u_classify (
        .clk             (clk),
        .rst_n           (rst_n),
        .exc_code_i      (exc_code_i),
        .halt_req_i      (halt_req_i),
        .ebreak_dbg_en_i (ebreak_dbg_en_i),
        .allow_i         (allow),
        .halt_exc_o      (halt_exc_o),
        .halt_irq_o      (halt_irq_o),
        .trap_o          (trap_o),
        .brk_dbg_o       (brk_dbg)
    );

    dbg_halt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (halt_exc_o || halt_irq_o),
        .in_debug_i (in_debug_i),
        .allow_o    (allow)
    );

    generate
        if (DEBUG_EN) begin : g_capture
            dbg_halt_capture #(.XLEN(XLEN)) u_capture (
                .clk        (clk),
                .rst_n      (rst_n),
                .halt_exc_i (halt_exc_o),
                .halt_irq_i (halt_irq_o),
                .brk_dbg_i  (brk_dbg),
                .pc_s3_i    (pc_s3_i),
                .pc_s2_i    (pc_s2_i),
                .dpc_o      (dpc_o),
                .cause_o    (cause_o)
            );
        end else begin : g_no_capture
            assign dpc_o   = '0;
            assign cause_o = '0;
        end
    endgenerate

    // R9
    off_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !DEBUG_EN |-> !(halt_exc_o || halt_irq_o));

    // R2
    ebreak_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEBUG_EN && ebreak_dbg_en_i && exc_code_i == EXC_EBREAK) |-> !trap_o);
endmodule

// File: tb/test_dbg_halt_ctrl.sv
module test_dbg_halt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      exc = 4'd15;
    logic [XLEN-1:0] pc3 = '0, pc2 = '0;
    logic            hr = 1'b0, en = 1'b0, indbg = 1'b0;
    logic            hx, hi, tr, hx_n, hi_n, tr_n;
    logic [XLEN-1:0] dpc, dpc_n;
    logic [2:0]      cause, cause_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_halt_ctrl #(.XLEN(XLEN), .DEBUG_EN(1'b1)) i_dbg_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_code_i(exc), .pc_s3_i(pc3), .pc_s2_i(pc2),
        .halt_req_i(hr), .ebreak_dbg_en_i(en), .in_debug_i(indbg),
        .halt_exc_o(hx), .halt_irq_o(hi), .trap_o(tr), .dpc_o(dpc), .cause_o(cause));

    dbg_halt_ctrl #(.XLEN(XLEN), .DEBUG_EN(1'b0)) i_dbg_halt_ctrl_nodbg (
        .clk(clk), .rst_n(rst_n), .exc_code_i(exc), .pc_s3_i(pc3), .pc_s2_i(pc2),
        .halt_req_i(hr), .ebreak_dbg_en_i(en), .in_debug_i(indbg),
        .halt_exc_o(hx_n), .halt_irq_o(hi_n), .trap_o(tr_n), .dpc_o(dpc_n), .cause_o(cause_n));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic brk, any, ex, irq, trp;
        logic [XLEN-1:0] held;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        // R10 reset state
        chk("R10 dpc", dpc, 0);
        chk("R10 cause", cause, 0);
        chk("R10 strobes", {hx, hi, tr}, 3'b000);

        for (int c = 0; c < 16; c++) begin
            for (int h = 0; h < 2; h++) begin
                for (int e = 0; e < 2; e++) begin
                    @(negedge clk);
                    exc = 4'(c); hr = 1'(h); en = 1'(e); indbg = 1'b0;
                    pc3 = 32'h1000 + 32'(c*64 + h*16 + e*8);
                    pc2 = pc3 + 32'd4;
                    #(CLK_PERIOD/4);
                    brk = (c == 3) && e[0];
                    any = (c != 15) && !brk;
                    ex  = brk || (h[0] && any);
                    irq = h[0] && !ex;
                    trp = any && !ex;
                    if (brk)               tag = "R2";
                    else if (h[0] && any)  tag = "R4";
                    else if (c == 3)       tag = "R3";
                    else if (h[0])         tag = "R1";
                    else                   tag = "R5";
                    chk({tag, " halt_exc"}, hx, ex);
                    chk({tag, " halt_irq"}, hi, irq);
                    chk({tag, " trap"}, tr, trp);
                    chk("R8 one style", {31'd0, hx & hi}, 0);
                    chk("R9 nodbg halts", {hx_n, hi_n}, 2'b00);
                    chk("R9 nodbg trap", tr_n, (c != 15));
                    chk("R9 nodbg dpc", dpc_n, 0);
                    held = dpc;
                    @(negedge clk);
                    if (ex || irq) begin
                        chk({tag, " dpc"}, dpc, ex ? pc3 : pc2);
                        chk({tag, " cause"}, cause, brk ? 3'd1 : 3'd3);
                        // ENTER: request held, flag still low
                        exc = 4'd15; hr = 1'b1; indbg = 1'b0;
                        #(CLK_PERIOD/4);
                        chk("R7 enter no strobe", {hx, hi}, 2'b00);
                        held = dpc;
                        @(negedge clk);
                        chk("R7 enter no strobe 2", {hx, hi}, 2'b00);
                        indbg = 1'b1;
                        #(CLK_PERIOD/4);
                        chk("R6 debug no strobe", {hx, hi}, 2'b00);
                        @(negedge clk);
                        chk("R6 halted dpc held", dpc, held);
                        chk("R7 halted no strobe", {hx, hi}, 2'b00);
                        indbg = 1'b0; hr = 1'b0;
                    end else begin
                        chk("R6 dpc hold", dpc, held);
                    end
                end
            end
        end

        // R6: flag high while in RUN, with request and a load fault
        @(negedge clk);
        exc = 4'd5; hr = 1'b1; en = 1'b0; indbg = 1'b1;
        held = dpc;
        #(CLK_PERIOD/4);
        chk("R6 run+debug strobes", {hx, hi}, 2'b00);
        chk("R6 run+debug trap", tr, 1'b1);
        @(negedge clk);
        chk("R6 run+debug dpc", dpc, held);
        exc = 4'd15; hr = 1'b0; indbg = 1'b0;
        @(negedge clk);
        // R4 final: back in RUN, halt request with load fault
        exc = 4'd5; hr = 1'b1; pc3 = 32'hABC0; pc2 = 32'hABC4;
        #(CLK_PERIOD/4);
        chk("R4 resume fault halt_exc", hx, 1'b1);
        chk("R4 resume fault trap", tr, 1'b0);
        @(negedge clk);
        chk("R4 resume fault dpc", dpc, 32'hABC0);
        chk("R4 resume fault cause", cause, 3'd3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule